// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This block sits on the host side of a legacy parallel port and carries out one register access to a remote adapter. It receives a request that holds a register number, a bank select, a read/write flag, a write byte and a transfer mode. It then runs a fixed series of pin steps on the port's data and control lines. Each step is held for a programmable number of clock cycles. For a read, the block captures the port's status lines, its control-line readback or its data lines at set points, and assembles the result byte according to the mode.

The register address goes onto the data lines after an XOR with a key that depends on the kind of access. Three read modes are supported. Nibble mode takes the two halves of the byte from the status lines in two separate samples. 5/3 mode takes five bits from status and three bits from the control readback in a single sample. Byte mode turns the data lines around and reads them directly. Writes follow one sequence in every mode. A caller raises `req_valid` while the block is idle, waits for the single-cycle `done`, and then reads `rdata`.

Top module: `ppreg_seq`

## Requirements
- R1: While reset is held and right after it, the data output is 0x00, the control output is 0x04, the direction output is 0, busy and done are 0, and rdata is 0x00.
- R2: A request is taken at a clock edge where `req_valid` is 1 and busy is 0. A request presented while busy is ignored. Busy is 1 from the cycle after acceptance up to the done cycle, and in the done cycle it is 0. Done is 1 for exactly one cycle.
- R3: The effective address is the register number plus 0x80 (modulo 256) when `req_bank` is 1, and the register number unchanged when it is 0. Step 0 of every access drives (effective address XOR key) on the data lines and leaves control as it was.
- R4: A nibble read (mode 0) uses key 0x39. After step 0 it runs control 0x01, control 0x03, the scrambled address driven again, control 0x01, then control 0x04. Status is sampled at the end of the address re-drive step (a) and at the end of the second 0x01 step (b).
- R5: The nibble result has status bits 7:4 of a in bits 3:0 and status bits 7:4 of b in bits 7:4.
- R6: A 5/3 read (mode 1) uses key 0x31. After step 0 it runs control 0x01, data (value AND 0x37), control 0x03, control 0x05, data (value OR 0xF0), then control 0x04. Status and control readback are sampled at the end of the OR step.
- R7: The 5/3 result has status bits 7:3 in bits 4:0 and control readback bits 3:1 in bits 7:5.
- R8: A byte read (mode 2) uses key 0x29. After step 0 it runs control 0x01, 0x21, 0x23, then 0x04. The data input is sampled at the end of the 0x23 step and becomes the result. Mode code 3 behaves exactly like mode 2.
- R9: A write uses key 0x19 in any mode. After step 0 it runs control 0x01, data = write byte, control 0x03, then control 0x04. It leaves rdata unchanged.
- R10: Every step lasts exactly D+1 cycles, where D is the `step_delay` value captured at acceptance. Later changes to `step_delay` do not affect an access already running.
- R11: The direction output equals control bit 5. It is 1 only during the 0x21 and 0x23 steps of a byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_bank | input | 1 | 1 selects the control bank (+0x80) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 8 | Register number |
| req_wdata | input | 8 | Write byte |
| req_mode | input | 2 | 0 nibble, 1 five/three, 2 or 3 byte |
| step_delay | input | DLY_W | Extra hold cycles per pin step |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Assembled read result |
| port_data_o | output | 8 | Data lines driven to the port |
| port_dir_o | output | 1 | 1 = data lines released for input |
| port_ctl_o | output | 8 | Control lines |
| port_data_i | input | 8 | Data lines read back |
| port_stat_i | input | 5 | Status lines 7:3 |
| port_ctlrb_i | input | 3 | Control readback lines 3:1 |

## Verification
On every cycle, the embedded properties check the handshake and the pin timing. They check that done is a lone pulse and that busy only falls into a done cycle. They check that control never changes while busy before it has been held D+1 cycles, that the direction output only rises during an access, and that control is back at 0x04 whenever the block is idle. The exact pin values of each step, the scrambling keys, the bank offset, the sample points and the way each mode assembles its result can only be shown by the bench. Its behavioural model predicts every pin and result cycle by cycle while the status, readback and data inputs change on every cycle.

// File: rtl/ppreg_seq.sv
module ppreg_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_bank,
  input  logic             req_write,
  input  logic [7:0]       req_reg,
  input  logic [7:0]       req_wdata,
  input  logic [1:0]       req_mode,
  input  logic [DLY_W-1:0] step_delay,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdata,
  output logic [7:0]       port_data_o,
  output logic             port_dir_o,
  output logic [7:0]       port_ctl_o,
  input  logic [7:0]       port_data_i,
  input  logic [7:3]       port_stat_i,
  input  logic [3:1]       port_ctlrb_i
);

  localparam logic [1:0] K_NIB  = 2'd0;
  localparam logic [1:0] K_53   = 2'd1;
  localparam logic [1:0] K_BYTE = 2'd2;
  localparam logic [1:0] K_WR   = 2'd3;

  localparam logic [2:0] D_KEEP = 3'd0;
  localparam logic [2:0] D_ADDR = 3'd1;
  localparam logic [2:0] D_AND  = 3'd2;
  localparam logic [2:0] D_OR   = 3'd3;
  localparam logic [2:0] D_WD   = 3'd4;

  localparam logic [2:0] S_NONE = 3'd0;
  localparam logic [2:0] S_A    = 3'd1;
  localparam logic [2:0] S_NIB  = 3'd2;
  localparam logic [2:0] S_53   = 3'd3;
  localparam logic [2:0] S_BYTE = 3'd4;

  localparam logic [7:0] CTL_IDLE = 8'h04;
  localparam int         HC_W     = DLY_W + 1;

  typedef struct packed {
    logic [2:0] dsel;
    logic       cset;
    logic [7:0] cval;
    logic [2:0] smp;
    logic       last;
  } step_t;

  function automatic step_t mk(input logic [2:0] d, input logic cs, input logic [7:0] cv,
                               input logic [2:0] sm, input logic ls);
    step_t t;
    t.dsel = d; t.cset = cs; t.cval = cv; t.smp = sm; t.last = ls;
    return t;
  endfunction

  function automatic step_t step_info(input logic [1:0] k, input logic [2:0] s);
    step_t t;
    t = mk(D_KEEP, 1'b0, 8'h00, S_NONE, 1'b1);
    if (s == 3'd0) t = mk(D_ADDR, 1'b0, 8'h00, S_NONE, 1'b0);
    else begin
      unique case (k)
        K_NIB: case (s)
          3'd1: t = mk(D_KEEP, 1'b1, 8'h01, S_NONE, 1'b0);
          3'd2: t = mk(D_KEEP, 1'b1, 8'h03, S_NONE, 1'b0);
          3'd3: t = mk(D_ADDR, 1'b0, 8'h00, S_A,    1'b0);
          3'd4: t = mk(D_KEEP, 1'b1, 8'h01, S_NIB,  1'b0);
          default: t = mk(D_KEEP, 1'b1, CTL_IDLE, S_NONE, 1'b1);
        endcase
        K_53: case (s)
          3'd1: t = mk(D_KEEP, 1'b1, 8'h01, S_NONE, 1'b0);
          3'd2: t = mk(D_AND,  1'b0, 8'h00, S_NONE, 1'b0);
          3'd3: t = mk(D_KEEP, 1'b1, 8'h03, S_NONE, 1'b0);
          3'd4: t = mk(D_KEEP, 1'b1, 8'h05, S_NONE, 1'b0);
          3'd5: t = mk(D_OR,   1'b0, 8'h00, S_53,   1'b0);
          default: t = mk(D_KEEP, 1'b1, CTL_IDLE, S_NONE, 1'b1);
        endcase
        K_BYTE: case (s)
          3'd1: t = mk(D_KEEP, 1'b1, 8'h01, S_NONE, 1'b0);
          3'd2: t = mk(D_KEEP, 1'b1, 8'h21, S_NONE, 1'b0);
          3'd3: t = mk(D_KEEP, 1'b1, 8'h23, S_BYTE, 1'b0);
          default: t = mk(D_KEEP, 1'b1, CTL_IDLE, S_NONE, 1'b1);
        endcase
        default: case (s)
          3'd1: t = mk(D_KEEP, 1'b1, 8'h01, S_NONE, 1'b0);
          3'd2: t = mk(D_WD,   1'b0, 8'h00, S_NONE, 1'b0);
          3'd3: t = mk(D_KEEP, 1'b1, 8'h03, S_NONE, 1'b0);
          default: t = mk(D_KEEP, 1'b1, CTL_IDLE, S_NONE, 1'b1);
        endcase
      endcase
    end
    return t;
  endfunction

  function automatic logic [7:0] pd_pick(input logic [2:0] sel, input logic [7:0] x,
                                         input logic [7:0] wd, input logic [7:0] keep);
    case (sel)
      D_ADDR:  return x;
      D_AND:   return x & 8'h37;
      D_OR:    return x | 8'hF0;
      D_WD:    return wd;
      default: return keep;
    endcase
  endfunction

  logic             busy_q, done_q;
  logic [1:0]       kind_q;
  logic [2:0]       step_q;
  logic [DLY_W-1:0] cnt_q, dly_q;
  logic [7:0]       x_q, wd_q, pd_q, pc_q, rdata_q;
  logic [7:4]       a_q;

  logic [1:0] req_kind;
  logic [7:0] req_key, req_x;
  step_t      st0, cur, nxt;

  assign req_kind = req_write ? K_WR : (req_mode == 2'd0) ? K_NIB :
                    (req_mode == 2'd1) ? K_53 : K_BYTE;
  assign req_key  = (req_kind == K_NIB) ? 8'h39 : (req_kind == K_53) ? 8'h31 :
                    (req_kind == K_BYTE) ? 8'h29 : 8'h19;
  assign req_x    = ({req_bank, 7'b0} + req_reg) ^ req_key;

  always_comb begin
    st0 = step_info(req_kind, 3'd0);
    cur = step_info(kind_q, step_q);
    nxt = step_info(kind_q, step_q + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; kind_q <= K_NIB; step_q <= '0;
      cnt_q <= '0; dly_q <= '0; x_q <= '0; wd_q <= '0;
      pd_q <= 8'h00; pc_q <= CTL_IDLE; rdata_q <= '0; a_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          kind_q <= req_kind;
          x_q    <= req_x;
          wd_q   <= req_wdata;
          dly_q  <= step_delay;
          cnt_q  <= step_delay;
          step_q <= '0;
          pd_q   <= pd_pick(st0.dsel, req_x, req_wdata, pd_q);
          if (st0.cset) pc_q <= st0.cval;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (cur.smp)
          S_A:    a_q     <= port_stat_i[7:4];
          S_NIB:  rdata_q <= {port_stat_i[7:4], a_q};
          S_53:   rdata_q <= {port_ctlrb_i, port_stat_i};
          S_BYTE: rdata_q <= port_data_i;
          default: ;
        endcase
        if (cur.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 3'd1;
          cnt_q  <= dly_q;
          pd_q   <= pd_pick(nxt.dsel, x_q, wd_q, pd_q);
          if (nxt.cset) pc_q <= nxt.cval;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign rdata       = rdata_q;
  assign port_data_o = pd_q;
  assign port_ctl_o  = pc_q;
  assign port_dir_o  = pc_q[5];

  logic [7:0]    prev_pc;
  logic [HC_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_pc  <= CTL_IDLE;
      hold_cnt <= '0;
    end else begin
      prev_pc <= port_ctl_o;
      if (port_ctl_o != prev_pc) hold_cnt <= '0;
      else if (hold_cnt != {HC_W{1'b1}}) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_fall_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  p_step_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && port_ctl_o != prev_pc) |-> (hold_cnt >= HC_W'(dly_q)));
  p_dir_in_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    port_dir_o |-> busy);
  p_idle_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (port_ctl_o == CTL_IDLE));

endmodule

// File: tb/ppreg_seq_test.sv
module ppreg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_bank = 0, req_write = 0;
  logic [7:0] req_reg = 0, req_wdata = 0;
  logic [1:0] req_mode = 0;
  logic [DLY_W-1:0] step_delay = 0;
  logic busy, done, port_dir_o;
  logic [7:0] rdata, port_data_o, port_ctl_o;
  logic [7:0] port_data_i = 0;
  logic [7:3] port_stat_i = 0;
  logic [3:1] port_ctlrb_i = 0;

  ppreg_seq #(.DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
    .req_mode(req_mode), .step_delay(step_delay), .busy(busy), .done(done),
    .rdata(rdata), .port_data_o(port_data_o), .port_dir_o(port_dir_o),
    .port_ctl_o(port_ctl_o), .port_data_i(port_data_i),
    .port_stat_i(port_stat_i), .port_ctlrb_i(port_ctlrb_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  int exp_pd = 0, exp_pc = 4, exp_rd = 0, a_save = 0, m_dl = 0, accepts = 0;
  bit exp_busy = 0, exp_done = 0;
  int q_pd[$], q_pc[$], q_smp[$];
  string q_tag[$];
  string rd_tag = "R5";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic push(input int pd, input int pc, input int smp, input string tag);
    for (int i = 0; i <= m_dl; i++) begin
      q_pd.push_back(pd); q_pc.push_back(pc);
      q_smp.push_back(i == m_dl ? smp : 0); q_tag.push_back(tag);
    end
  endtask

  // Builds the expected per-cycle pin sequence from the requirements
  task automatic build(input bit bank, input bit wr, input int rg, input int wd, input int mode, input int dl);
    int addr, x, lc;
    m_dl = dl;
    addr = (rg + (bank ? 128 : 0)) & 255;
    lc = exp_pc;
    accepts++;
    if (wr) begin
      x = addr ^ 'h19;  // R9
      push(x, lc, 0, "R3"); push(x, 1, 0, "R9 R10"); push(wd, 1, 0, "R9 R10");
      push(wd, 3, 0, "R9 R10"); push(wd, 4, 0, "R9 R10");
    end else if (mode == 0) begin
      x = addr ^ 'h39;  // R4
      rd_tag = "R5";
      push(x, lc, 0, "R3"); push(x, 1, 0, "R4 R10"); push(x, 3, 0, "R4 R10");
      push(x, 3, 1, "R4 R10"); push(x, 1, 2, "R4 R10"); push(x, 4, 0, "R4 R10");
    end else if (mode == 1) begin
      x = addr ^ 'h31;  // R6
      rd_tag = "R7";
      push(x, lc, 0, "R3"); push(x, 1, 0, "R6 R10"); push(x & 'h37, 1, 0, "R6 R10");
      push(x & 'h37, 3, 0, "R6 R10"); push(x & 'h37, 5, 0, "R6 R10");
      push(x | 'hF0, 5, 3, "R6 R10"); push(x | 'hF0, 4, 0, "R6 R10");
    end else begin
      x = addr ^ 'h29;  // R8 (mode 3 too)
      rd_tag = "R8";
      push(x, lc, 0, "R3"); push(x, 1, 0, "R8 R10"); push(x, 'h21, 0, "R8 R10");
      push(x, 'h23, 4, "R8 R10"); push(x, 4, 0, "R8 R10");
    end
  endtask

  task automatic cyc(input bit v, input bit bank, input bit wr, input int rg,
                     input int wd, input int mode, input int dl);
    string ptag;
    int smp;
    @(negedge clk);
    ptag = (q_tag.size() > 0) ? q_tag[0] : "R2";
    chk(port_data_o == 8'(exp_pd), ptag, "data_o", port_data_o, exp_pd);
    chk(port_ctl_o == 8'(exp_pc), ptag, "ctl_o", port_ctl_o, exp_pc);
    chk(port_dir_o == exp_pc[5], "R11", "dir", port_dir_o, exp_pc[5]);
    chk(busy == exp_busy, "R2", "busy", busy, exp_busy);
    chk(done == exp_done, "R2", "done", done, exp_done);
    chk(rdata == 8'(exp_rd), rd_tag, "rdata", rdata, exp_rd);
    req_valid = v; req_bank = bank; req_write = wr; req_reg = 8'(rg);
    req_wdata = 8'(wd); req_mode = 2'(mode); step_delay = DLY_W'(dl);
    port_data_i = 8'($urandom); port_stat_i = 5'($urandom); port_ctlrb_i = 3'($urandom);
    if (!rst_n) return;
    if (q_pd.size() > 0) begin
      smp = q_smp[0];
      void'(q_pd.pop_front()); void'(q_pc.pop_front());
      void'(q_smp.pop_front()); void'(q_tag.pop_front());
      if (smp == 1) a_save = (int'(port_stat_i) >> 1) & 'hF;
      if (smp == 2) exp_rd = (((int'(port_stat_i) >> 1) & 'hF) << 4) | a_save;
      if (smp == 3) exp_rd = (int'(port_ctlrb_i) << 5) | int'(port_stat_i);
      if (smp == 4) exp_rd = int'(port_data_i);
      if (q_pd.size() == 0) begin
        exp_busy = 0; exp_done = 1;
      end else begin
        exp_pd = q_pd[0]; exp_pc = q_pc[0]; exp_busy = 1; exp_done = 0;
      end
    end else begin
      exp_done = 0;
      if (v) begin
        build(bank, wr, rg, wd, mode, dl);
        exp_pd = q_pd[0]; exp_pc = q_pc[0]; exp_busy = 1;
      end
    end
  endtask

  task automatic idle_until_quiet();
    while (q_pd.size() > 0 || exp_done) cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic access(input bit bank, input bit wr, input int rg, input int wd,
                        input int mode, input int dl);
    cyc(1, bank, wr, rg, wd, mode, dl);
    idle_until_quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int start;
    // R1: reset state, during and after reset
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) cyc(0, 0, 0, 0, 0, 0, 0);
    chk(port_ctl_o == 8'h04 && port_data_o == 8'h00 && !busy && rdata == 0, "R1",
        "reset state", {port_ctl_o, port_data_o}, 'h0400);

    // R4 R5: nibble reads, command and control bank (R3)
    access(0, 0, 'h05, 0, 0, 0);
    access(1, 0, 'h07, 0, 0, 2);
    // R6 R7: five/three reads
    access(0, 0, 'h11, 0, 1, 1);
    access(1, 0, 'hA5, 0, 1, 0);   // R3 wrap: 0xA5+0x80 = 0x25
    // R8: byte reads, mode 2 and mode 3
    access(0, 0, 'h02, 0, 2, 3);
    access(1, 0, 'h06, 0, 3, 1);
    // R9: writes in every mode, rdata must hold
    access(0, 1, 'h03, 'h5A, 0, 0);
    access(1, 1, 'h86, 'hC3, 1, 2);
    access(0, 1, 'h7F, 'hFF, 2, 1);

    // R2: requests during busy are ignored
    cyc(1, 0, 0, 'h10, 0, 0, 1);
    repeat (3) cyc(1, 1, 1, 'h44, 'h99, 2, 0);
    idle_until_quiet();

    // R10: delay changes mid-access have no effect
    cyc(1, 0, 0, 'h21, 0, 1, 2);
    repeat (4) cyc(0, 0, 0, 0, 0, 0, 7);
    idle_until_quiet();

    // R2: request held across done is taken in the done cycle
    start = accepts;
    cyc(1, 0, 1, 'h09, 'h12, 0, 0);
    while (accepts < start + 2) cyc(1, 1, 0, 'h0C, 0, 0, 1);
    idle_until_quiet();

    // mixed accesses over all modes and delays
    for (int i = 0; i < 60; i++)
      access($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255),
             $urandom_range(0, 255), $urandom_range(0, 3), $urandom_range(0, 4));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule